// File: doc/BRIEF.md
# Floppy Drive Register and Command Model

A synthesizable behavioural model of a 3.5-inch floppy drive as it appears on its register-select wires. A 4-bit selector, ordered {ca2, ca1, ca0, head select}, does two jobs. It picks which 1-bit drive status line appears on `sense`. It also names the command that a rising edge on `strobe` applies while `enable` is high. The model keeps the drive's state: head direction, track position, spindle motor, disk presence and a pending eject.

All delays are counted in pulses of the `tick` time base. These are the head step settle time, the longer settle time when the head crosses into another speed group, the motor spin-up time, and the strobe hold time an eject needs. Because the tick counts are parameters, a simulation can shrink them. While the motor runs, a tachometer line toggles at a rate that follows the speed group of the current track. Magnetic data, track bit storage and PWM speed decoding are not modelled. The live read bits come straight from input pins.

Top module: `floppy_drive_model`

## Requirements
- R1: `sense` follows the selector `sel` = {ca2,ca1,ca0,hsel} with no clock delay. 0000 gives direction, 0001 gives disk-missing (0 = disk in), 0010 gives head-settled (0 = stepping), 0011 gives `~write_prot` (0 = protected), 0100 gives motor-stopped (0 = running), 0101 gives not-at-track-0 (0 = track 0), and 0111 gives the tachometer. 1000 and 1001 give `rd_bit_lo` and `rd_bit_hi`. 1100 gives the TWO_SIDED parameter, 1101 gives not-ready (0 = ready), and 1110 gives 0 (drive installed). Every other code gives 1.
- R2: Command 000 sets the direction to up, so direction sense reads 0. Command 100 sets it to down, so direction sense reads 1. Commands use hsel = 0, and the 3-bit code is {ca2,ca1,ca0}.
- R3: A command acts only in the clock cycle where `strobe` rises while `enable` = 1 and hsel = 0. A strobe edge with `enable` = 0 or with hsel = 1 changes nothing.
- R4: Command 001 (step) moves `track` one place in the latched direction. The track stays within 0 to MAX_TRACK and holds at either end. Reset puts the track at 0.
- R5: A step loads a settle timer of STEP_TICKS ticks, and the head reads as stepping until the timer runs out. A step command that arrives while the head is still stepping is ignored.
- R6: A step that moves into another 16-track speed group loads GROUP_TICKS instead of STEP_TICKS.
- R7: Command 010 (motor on) starts the motor only when a disk is present. Command 110 (motor off) stops it.
- R8: The drive reads ready once the motor has run for SPIN_TICKS ticks after motor on. Stopping the motor clears ready.
- R9: Command 111 (eject) removes the disk and stops the motor only if `strobe` and `enable` stay high for EJECT_TICKS ticks after the edge. A shorter pulse changes nothing.
- R10: `disk_insert` = 1 marks a disk as present. If an eject completes in the same cycle, the eject wins.
- R11: While the motor runs, the tachometer toggles every TACH_SCALE/rpm ticks. The rpm is 402, 438, 482, 536 or 603 for tracks 0–15, 16–31, 32–47, 48–63 and 64 and up. While the motor is stopped, the line holds its value.
- R12: After reset the drive has direction up, no disk, the motor stopped, the head settled, track 0 and the tachometer low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base pulse; all delays count these |
| sel | input | 4 | {ca2, ca1, ca0, head select} |
| enable | input | 1 | Drive enable; gates commands |
| strobe | input | 1 | Command strobe, active on its rising edge |
| disk_insert | input | 1 | Marks a disk as inserted |
| write_prot | input | 1 | 1 = inserted disk is write protected |
| rd_bit_lo | input | 1 | Live read bit, lower head |
| rd_bit_hi | input | 1 | Live read bit, upper head |
| sense | output | 1 | Selected status bit |
| track | output | $clog2(MAX_TRACK+1) | Current head track |

## Verification
The bench steps the head across many tracks in both directions. It hits both clamps, which separates a correct one-track step from wrap-around and double steps. It times the settle window both inside one speed group and across a group boundary, which separates the short delay from the long one. Strobe patterns cover a missing enable, head select set, a pulse during a busy head, and short and long eject holds. These patterns separate edge-gated commands from level-gated ones, and a completed eject from an aborted one. The selector is swept across every code while the motor runs, so each status line and the tachometer rate are compared every clock against a behavioural model.

// File: rtl/drv_model_pkg.sv
package drv_model_pkg;

    typedef enum logic [2:0] {
        CMD_DIR_UP    = 3'b000,
        CMD_STEP      = 3'b001,
        CMD_MOTOR_ON  = 3'b010,
        CMD_DIR_DOWN  = 3'b100,
        CMD_MOTOR_OFF = 3'b110,
        CMD_EJECT     = 3'b111
    } drv_cmd_e;

    localparam int NUM_GROUPS  = 5;
    localparam int GROUP_SHIFT = 4;

    // nominal spindle speed of each 16-track group
    function automatic int group_rpm(input int grp);
        case (grp)
            0:       return 402;
            1:       return 438;
            2:       return 482;
            3:       return 536;
            default: return 603;
        endcase
    endfunction

endpackage

// File: rtl/drv_cmd_decode.sv
module drv_cmd_decode
    import drv_model_pkg::*;
(
    input  logic [3:0] sel,
    input  logic       enable,
    input  logic       strobe,
    input  logic       strobe_q,
    output logic       cmd_valid,
    output drv_cmd_e   cmd
);
    logic rise;
    logic known;

    assign rise = strobe & ~strobe_q;

    always_comb begin
        case (sel[3:1])
            3'b000, 3'b001, 3'b010, 3'b100, 3'b110, 3'b111: known = 1'b1;
            default:                                         known = 1'b0;
        endcase
    end

    assign cmd       = drv_cmd_e'(sel[3:1]);
    assign cmd_valid = rise & enable & ~sel[0] & known;
endmodule

// File: rtl/drv_tach_period.sv
module drv_tach_period
    import drv_model_pkg::*;
#(
    parameter int TACH_SCALE = 4020,
    parameter int TW         = 7,
    parameter int CW         = 16
) (
    input  logic [TW-1:0] trk,
    output logic [CW-1:0] half
);
    localparam int GW = TW - GROUP_SHIFT;

    logic [CW-1:0] half_tab [NUM_GROUPS];
    logic [GW-1:0] grp;

    generate
        for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_tab
            localparam int RAW = TACH_SCALE / group_rpm(g);
            localparam int VAL = (RAW < 1) ? 1 : RAW;
            assign half_tab[g] = CW'(VAL);
        end
    endgenerate

    assign grp  = trk[TW-1:GROUP_SHIFT];
    assign half = (int'(grp) >= NUM_GROUPS - 1) ? half_tab[NUM_GROUPS-1] : half_tab[grp];
endmodule

// File: rtl/drv_sense_mux.sv
module drv_sense_mux #(
    parameter bit TWO_SIDED = 1'b1
) (
    input  logic [3:0] sel,
    input  logic       dir_down,
    input  logic       disk_in,
    input  logic       stepping,
    input  logic       write_prot,
    input  logic       motor_run,
    input  logic       at_zero,
    input  logic       tach,
    input  logic       rd_lo,
    input  logic       rd_hi,
    input  logic       ready,
    output logic       sense
);
    always_comb begin
        case (sel)
            4'b0000: sense = dir_down;
            4'b0001: sense = ~disk_in;
            4'b0010: sense = ~stepping;
            4'b0011: sense = ~write_prot;
            4'b0100: sense = ~motor_run;
            4'b0101: sense = ~at_zero;
            4'b0111: sense = tach;
            4'b1000: sense = rd_lo;
            4'b1001: sense = rd_hi;
            4'b1100: sense = TWO_SIDED;
            4'b1101: sense = ~ready;
            4'b1110: sense = 1'b0;
            default: sense = 1'b1;
        endcase
    end
endmodule

// File: rtl/floppy_drive_model.sv
module floppy_drive_model
    import drv_model_pkg::*;
#(
    parameter int MAX_TRACK   = 79,
    parameter int STEP_TICKS  = 30,
    parameter int GROUP_TICKS = 150,
    parameter int SPIN_TICKS  = 400,
    parameter int EJECT_TICKS = 750,
    parameter int TACH_SCALE  = 4020,
    parameter bit TWO_SIDED   = 1'b1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           tick,
    input  logic [3:0]                     sel,
    input  logic                           enable,
    input  logic                           strobe,
    input  logic                           disk_insert,
    input  logic                           write_prot,
    input  logic                           rd_bit_lo,
    input  logic                           rd_bit_hi,
    output logic                           sense,
    output logic [$clog2(MAX_TRACK+1)-1:0] track
);
    localparam int TW   = $clog2(MAX_TRACK + 1);
    localparam int M1   = (STEP_TICKS > GROUP_TICKS) ? STEP_TICKS : GROUP_TICKS;
    localparam int M2   = (SPIN_TICKS > EJECT_TICKS) ? SPIN_TICKS : EJECT_TICKS;
    localparam int M3   = (M1 > M2) ? M1 : M2;
    localparam int MAXC = (M3 > TACH_SCALE) ? M3 : TACH_SCALE;
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        logic          strobe;
        logic          dir_down;
        logic [TW-1:0] trk;
        logic [CW-1:0] busy_cnt;
        logic          disk;
        logic          motor;
        logic [CW-1:0] spin_cnt;
        logic          ej_arm;
        logic [CW-1:0] ej_cnt;
        logic          tach;
        logic [CW-1:0] tach_cnt;
    } drv_state_t;

    drv_state_t s_q, s_d;

    logic          cmd_valid;
    drv_cmd_e      cmd;
    logic [CW-1:0] tach_half;
    logic [TW-1:0] nxt_trk;
    logic          stepping;
    logic          ready;

    drv_cmd_decode u_dec (
        .sel       (sel),
        .enable    (enable),
        .strobe    (strobe),
        .strobe_q  (s_q.strobe),
        .cmd_valid (cmd_valid),
        .cmd       (cmd)
    );

    drv_tach_period #(
        .TACH_SCALE (TACH_SCALE),
        .TW         (TW),
        .CW         (CW)
    ) u_tach (
        .trk  (s_q.trk),
        .half (tach_half)
    );

    assign stepping = (s_q.busy_cnt != '0);
    assign ready    = s_q.motor & (s_q.spin_cnt == '0);

    // candidate track for a step, held at the end stops
    always_comb begin
        nxt_trk = s_q.trk;
        if (s_q.dir_down) begin
            if (s_q.trk != '0) nxt_trk = s_q.trk - 1'b1;
        end else begin
            if (s_q.trk != TW'(MAX_TRACK)) nxt_trk = s_q.trk + 1'b1;
        end
    end

    always_comb begin
        s_d        = s_q;
        s_d.strobe = strobe;

        // settle and spin-up timers
        if (tick && stepping) s_d.busy_cnt = s_q.busy_cnt - 1'b1;
        if (tick && s_q.motor && s_q.spin_cnt != '0) s_d.spin_cnt = s_q.spin_cnt - 1'b1;

        // tachometer
        if (!s_q.motor) begin
            s_d.tach_cnt = '0;
        end else if (tick) begin
            if (s_q.tach_cnt + 1'b1 >= tach_half) begin
                s_d.tach     = ~s_q.tach;
                s_d.tach_cnt = '0;
            end else begin
                s_d.tach_cnt = s_q.tach_cnt + 1'b1;
            end
        end

        // eject hold window
        if (s_q.ej_arm) begin
            if (!strobe || !enable) begin
                s_d.ej_arm = 1'b0;
            end else if (tick) begin
                s_d.ej_cnt = s_q.ej_cnt + 1'b1;
            end
        end

        if (disk_insert) s_d.disk = 1'b1;

        if (cmd_valid) begin
            case (cmd)
                CMD_DIR_UP:   s_d.dir_down = 1'b0;
                CMD_DIR_DOWN: s_d.dir_down = 1'b1;
                CMD_STEP: begin
                    if (!stepping) begin
                        s_d.trk = nxt_trk;
                        if (nxt_trk[TW-1:GROUP_SHIFT] != s_q.trk[TW-1:GROUP_SHIFT])
                            s_d.busy_cnt = CW'(GROUP_TICKS);
                        else
                            s_d.busy_cnt = CW'(STEP_TICKS);
                    end
                end
                CMD_MOTOR_ON: begin
                    if (s_q.disk) begin
                        s_d.motor    = 1'b1;
                        s_d.spin_cnt = CW'(SPIN_TICKS);
                    end
                end
                CMD_MOTOR_OFF: begin
                    s_d.motor    = 1'b0;
                    s_d.spin_cnt = '0;
                end
                CMD_EJECT: begin
                    s_d.ej_arm = 1'b1;
                    s_d.ej_cnt = '0;
                end
                default: ;
            endcase
        end

        // completed eject overrides insert and motor
        if (s_q.ej_arm && strobe && enable && tick && s_q.ej_cnt == CW'(EJECT_TICKS - 1)) begin
            s_d.ej_arm   = 1'b0;
            s_d.ej_cnt   = '0;
            s_d.disk     = 1'b0;
            s_d.motor    = 1'b0;
            s_d.spin_cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    drv_sense_mux #(.TWO_SIDED(TWO_SIDED)) u_mux (
        .sel        (sel),
        .dir_down   (s_q.dir_down),
        .disk_in    (s_q.disk),
        .stepping   (stepping),
        .write_prot (write_prot),
        .motor_run  (s_q.motor),
        .at_zero    (s_q.trk == '0),
        .tach       (s_q.tach),
        .rd_lo      (rd_bit_lo),
        .rd_hi      (rd_bit_hi),
        .ready      (ready),
        .sense      (sense)
    );

    assign track = s_q.trk;
endmodule

// File: rtl/drv_model_chk.sv
module drv_model_chk #(
    parameter int MAX_TRACK = 79,
    parameter int TW        = 7,
    parameter int CW        = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    sel,
    input logic          enable,
    input logic          strobe,
    input logic [TW-1:0] track,
    input logic          disk_q,
    input logic          motor_q,
    input logic          ej_arm_q,
    input logic [CW-1:0] busy_cnt_q
);
    // R4
    track_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        track <= TW'(MAX_TRACK));

    // R4
    track_single_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (track != $past(track)) |-> (track == $past(track) + 1'b1 || track == $past(track) - 1'b1));

    // R3
    track_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (track != $past(track)) |-> $past(strobe && enable && sel == 4'b0010));

    // R7
    motor_needs_disk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        motor_q |-> disk_q);

    // R9
    eject_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(disk_q) |-> $past(ej_arm_q && strobe && enable));

    // R5
    busy_reload_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_cnt_q > $past(busy_cnt_q)) |-> ($past(busy_cnt_q) == '0));
endmodule

bind floppy_drive_model drv_model_chk #(
    .MAX_TRACK (MAX_TRACK),
    .TW        (TW),
    .CW        (CW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (sel),
    .enable     (enable),
    .strobe     (strobe),
    .track      (track),
    .disk_q     (s_q.disk),
    .motor_q    (s_q.motor),
    .ej_arm_q   (s_q.ej_arm),
    .busy_cnt_q (s_q.busy_cnt)
);

// File: tb/tb_floppy_drive_model.sv
`timescale 1ns/1ps
module tb_floppy_drive_model;
    localparam int MAX_TRACK   = 79;
    localparam int STEP_TICKS  = 3;
    localparam int GROUP_TICKS = 7;
    localparam int SPIN_TICKS  = 5;
    localparam int EJECT_TICKS = 9;
    localparam int TACH_SCALE  = 4020;
    localparam int TW          = $clog2(MAX_TRACK + 1);

    logic clk = 0;
    logic rst_n = 0;
    logic tick = 0;
    logic [3:0] sel = 0;
    logic enable = 0, strobe = 0, disk_insert = 0, write_prot = 0;
    logic rd_bit_lo = 0, rd_bit_hi = 0;
    logic sense;
    logic [TW-1:0] track;

    int total = 0, bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    floppy_drive_model #(
        .MAX_TRACK(MAX_TRACK), .STEP_TICKS(STEP_TICKS), .GROUP_TICKS(GROUP_TICKS),
        .SPIN_TICKS(SPIN_TICKS), .EJECT_TICKS(EJECT_TICKS), .TACH_SCALE(TACH_SCALE),
        .TWO_SIDED(1'b1)
    ) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sel(sel), .enable(enable),
        .strobe(strobe), .disk_insert(disk_insert), .write_prot(write_prot),
        .rd_bit_lo(rd_bit_lo), .rd_bit_hi(rd_bit_hi), .sense(sense), .track(track)
    );

    // tick every third clock
    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1 tick = ((cyc % 3) == 0);
    end

    // ---------------- behavioural reference ----------------
    int m_trk, m_busy, m_spin, m_ej, m_tc;
    bit m_down, m_disk, m_motor, m_tach, m_arm, m_prev;

    function automatic int rpm_for(int t);
        if (t < 16) return 402;
        if (t < 32) return 438;
        if (t < 48) return 482;
        if (t < 64) return 536;
        return 603;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_trk = 0; m_busy = 0; m_spin = 0; m_ej = 0; m_tc = 0;
            m_down = 0; m_disk = 0; m_motor = 0; m_tach = 0; m_arm = 0; m_prev = 0;
        end else begin
            bit go, fin;
            int half, o_trk, o_busy;
            bit o_disk, o_motor;
            go = strobe && !m_prev && enable && !sel[0];
            fin = m_arm && strobe && enable && tick && (m_ej == EJECT_TICKS - 1);
            half = TACH_SCALE / rpm_for(m_trk);
            if (half < 1) half = 1;
            o_trk = m_trk; o_busy = m_busy; o_disk = m_disk; o_motor = m_motor;
            m_prev = strobe;
            if (tick && m_busy > 0) m_busy--;
            if (tick && o_motor && m_spin > 0) m_spin--;
            if (!o_motor) m_tc = 0;
            else if (tick) begin
                if (m_tc + 1 >= half) begin m_tach = !m_tach; m_tc = 0; end
                else m_tc++;
            end
            if (m_arm) begin
                if (!strobe || !enable) m_arm = 0;
                else if (tick) m_ej++;
            end
            if (disk_insert) m_disk = 1;
            if (go) begin
                case (sel[3:1])
                    3'b000: m_down = 0;
                    3'b100: m_down = 1;
                    3'b001: if (o_busy == 0) begin
                        int n;
                        n = m_down ? (o_trk > 0 ? o_trk - 1 : 0)
                                   : (o_trk < MAX_TRACK ? o_trk + 1 : MAX_TRACK);
                        m_busy = (n / 16 != o_trk / 16) ? GROUP_TICKS : STEP_TICKS;
                        m_trk = n;
                    end
                    3'b010: if (o_disk) begin m_motor = 1; m_spin = SPIN_TICKS; end
                    3'b110: begin m_motor = 0; m_spin = 0; end
                    3'b111: begin m_arm = 1; m_ej = 0; end
                    default: ;
                endcase
            end
            if (fin) begin
                m_arm = 0; m_ej = 0; m_disk = 0; m_motor = 0; m_spin = 0;
            end
        end
    end

    function automatic bit exp_sense(logic [3:0] s);
        case (s)
            4'b0000: return m_down;
            4'b0001: return !m_disk;
            4'b0010: return m_busy == 0;
            4'b0011: return !write_prot;
            4'b0100: return !m_motor;
            4'b0101: return m_trk != 0;
            4'b0111: return m_tach;
            4'b1000: return rd_bit_lo;
            4'b1001: return rd_bit_hi;
            4'b1100: return 1'b1;
            4'b1101: return !(m_motor && m_spin == 0);
            4'b1110: return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    function automatic string tag_of(logic [3:0] s);
        case (s)
            4'b0010: return "R5";
            4'b0100: return "R7";
            4'b1101: return "R8";
            4'b0001: return "R10";
            4'b0111: return "R11";
            4'b0101: return "R4";
            default: return "R1";
        endcase
    endfunction

    // every-clock comparison
    always @(negedge clk) begin
        if (rst_n && !done) begin
            total++;
            if (sense !== exp_sense(sel)) begin
                bad++;
                $display("FAIL %s sel=%b sense actual=%0b expected=%0b", tag_of(sel), sel, sense, exp_sense(sel));
            end
            total++;
            if (int'(track) != m_trk) begin
                bad++;
                $display("FAIL R4 track actual=%0d expected=%0d", track, m_trk);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(string req, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic clocks(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic peek(logic [3:0] s, output bit v);
        sel = s;
        @(negedge clk);
        v = sense;
        @(posedge clk); #1;
    endtask

    task automatic pulse(logic [3:0] s, bit en, int hold);
        sel = s; enable = en; strobe = 1;
        clocks(hold);
        strobe = 0;
        clocks(1);
    endtask

    task automatic settle();
        bit v;
        do peek(4'b0010, v); while (v == 0);
    endtask

    task automatic step_once();
        pulse(4'b0010, 1, 1);
        settle();
    endtask

    task automatic busy_len(output int n);
        bit v;
        pulse(4'b0010, 1, 1);
        n = 0;
        sel = 4'b0010;
        forever begin
            @(negedge clk);
            if (sense) break;
            n++;
        end
        @(posedge clk); #1;
    endtask

    // ---------------- stimulus ----------------
    initial begin
        bit v;
        int t1, t2, edges;
        clocks(4);
        rst_n = 1;
        clocks(1);

        // R12 reset state
        peek(4'b0000, v); check("R12 direction up", v, 0);
        peek(4'b0001, v); check("R12 no disk", v, 1);
        peek(4'b0100, v); check("R12 motor off", v, 1);
        peek(4'b0101, v); check("R12 at track 0", v, 0);
        peek(4'b0010, v); check("R12 head settled", v, 1);
        check("R12 track", int'(track), 0);

        // R1 fixed and pass-through codes
        peek(4'b1100, v); check("R1 sides", v, 1);
        peek(4'b1110, v); check("R1 installed", v, 0);
        peek(4'b0110, v); check("R1 unused code", v, 1);
        rd_bit_lo = 1; rd_bit_hi = 0;
        peek(4'b1000, v); check("R1 lower read bit", v, 1);
        peek(4'b1001, v); check("R1 upper read bit", v, 0);
        write_prot = 1;
        peek(4'b0011, v); check("R1 write protect", v, 0);
        write_prot = 0;

        // R3 gated strobes
        pulse(4'b0010, 0, 2);
        check("R3 no enable", int'(track), 0);
        pulse(4'b0011, 1, 2);
        check("R3 head select set", int'(track), 0);
        enable = 1;
        sel = 4'b0010; clocks(2);
        check("R3 level without edge", int'(track), 0);

        // R7 motor on with no disk
        pulse(4'b0100, 1, 1);
        peek(4'b0100, v); check("R7 no disk no motor", v, 1);

        // R10 insert
        disk_insert = 1; clocks(1); disk_insert = 0;
        peek(4'b0001, v); check("R10 disk present", v, 0);

        // R7/R8 spin up
        pulse(4'b0100, 1, 1);
        peek(4'b0100, v); check("R7 motor running", v, 0);
        peek(4'b1101, v); check("R8 not yet ready", v, 1);
        clocks(3 * SPIN_TICKS + 3);
        peek(4'b1101, v); check("R8 ready", v, 0);

        // R11 tachometer at group 0: half period 10 ticks = 30 clocks
        sel = 4'b0111; edges = 0;
        @(negedge clk); v = sense;
        for (int i = 0; i < 120; i++) begin
            @(negedge clk);
            if (sense != v) edges++;
            v = sense;
        end
        total++;
        if (edges < 3 || edges > 5) begin
            bad++;
            $display("FAIL R11 tach edges actual=%0d expected=3..5", edges);
        end
        @(posedge clk); #1;

        // R2 direction
        pulse(4'b1000, 1, 1);
        peek(4'b0000, v); check("R2 direction down", v, 1);
        step_once();
        check("R4 clamp at 0", int'(track), 0);
        pulse(4'b0000, 1, 1);
        peek(4'b0000, v); check("R2 direction up", v, 0);

        // R5 busy and ignored second step
        pulse(4'b0010, 1, 1);
        peek(4'b0010, v); check("R5 stepping", v, 0);
        pulse(4'b0010, 1, 1);
        settle();
        check("R5 step during busy ignored", int'(track), 1);

        // R4 walk to track 14, then time in-group and cross-group steps
        for (int i = 1; i < 14; i++) step_once();
        check("R4 track after steps", int'(track), 14);
        busy_len(t1);
        busy_len(t2);
        check("R6 crossed to 16", int'(track), 16);
        total++;
        if (t2 < t1 + 3 * (GROUP_TICKS - STEP_TICKS) - 3) begin
            bad++;
            $display("FAIL R6 group busy actual=%0d expected>=%0d", t2, t1 + 3 * (GROUP_TICKS - STEP_TICKS) - 3);
        end

        // sweep every code while motor runs
        for (int s = 0; s < 16; s++) begin sel = 4'(s); clocks(3); end

        // R4 upper clamp
        while (int'(track) < MAX_TRACK) step_once();
        step_once();
        check("R4 clamp at max", int'(track), MAX_TRACK);
        sel = 4'b0111; clocks(60);

        // R9 short eject pulse ignored
        pulse(4'b1110, 1, 3 * EJECT_TICKS - 8);
        peek(4'b0001, v); check("R9 short eject keeps disk", v, 0);
        peek(4'b0100, v); check("R9 short eject keeps motor", v, 0);

        // R8 motor off
        pulse(4'b1100, 1, 1);
        peek(4'b1101, v); check("R8 motor off not ready", v, 1);
        pulse(4'b0100, 1, 1);
        clocks(3 * SPIN_TICKS + 3);

        // R9 long eject
        pulse(4'b1110, 1, 3 * EJECT_TICKS + 6);
        peek(4'b0001, v); check("R9 disk ejected", v, 1);
        peek(4'b0100, v); check("R9 motor stopped", v, 1);

        // R10 insert loses to simultaneous eject completion: covered by model each clock
        disk_insert = 1; clocks(1); disk_insert = 0;
        peek(4'b0001, v); check("R10 reinsert", v, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule